// File: doc/BRIEF.md
# Dual-Context Register File with Write Forwarding

This block stores the integer operands of a simple in-order pipeline. It holds two complete sets of thirty-two 32-bit registers: a main set and a shadow set. A one-bit set selector on the read side and another on the write side choose which set each access uses. On interrupt entry, control logic elsewhere changes the selectors, and the handler then runs in the shadow set without spilling the main registers to memory. Because the two selectors are separate, the pipeline can still read values from the set it is leaving while it retires results into the set it has entered.

There are two asynchronous read ports and one write port that commits on the clock edge. A result on the write port that targets the register a read port is addressing, in the same set, appears on that read port in the same cycle. Register 0 of each set is hard-wired to zero.

Top module: `rf_banked`

## Requirements
- R1: The file holds NBANK (default 2) sets of NREG (default 32) registers of XLEN (default 32) bits. Set code 0 is the main set and code 1 is the shadow set. A write into one set leaves every register of the other set unchanged.
- R2: Each read port is combinational. When no forwarding applies, it returns the stored value of the register at its index in the set chosen by `rd_bank`.
- R3: When `wr_en` is high and `rst` is low, `wr_data` is stored into register `wr_idx` of set `wr_bank` at the rising clock edge. The stored value is visible on the read ports from the next cycle on.
- R4: Index 0 reads as zero on both ports in every set. A write to index 0 is discarded and does not forward.
- R5: When `wr_en` is high, `rst` is low, `wr_bank` equals `rd_bank`, and `wr_idx` equals a nonzero read index, that read port returns `wr_data` in the same cycle. This holds for each port on its own.
- R6: A write into a set other than `rd_bank` is never forwarded. The read returns the value stored before the write.
- R7: Synchronous active-high `rst` clears every register of every set at the clock edge. While `rst` is high, writes are dropped and no forwarding takes place.
- R8: When `wr_en` is low, no register changes, whatever `wr_idx`, `wr_bank` and `wr_data` carry.
- R9: The two read ports are independent. When they carry the same index, they return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst | input | 1 | Synchronous active-high clear of all sets |
| rd_bank | input | $clog2(NBANK) | Set used by both read ports |
| a_idx | input | $clog2(NREG) | Register index of read port A |
| a_data | output | XLEN | Read data of port A |
| b_idx | input | $clog2(NREG) | Register index of read port B |
| b_data | output | XLEN | Read data of port B |
| wr_en | input | 1 | Write enable |
| wr_bank | input | $clog2(NBANK) | Set that receives the write |
| wr_idx | input | $clog2(NREG) | Register index of the write |
| wr_data | input | XLEN | Write data |

## Verification
The hardest case to reach from the ports is the forwarding decision itself. It depends on four things at once in a single cycle: the write set, the read set, the write index and the read index. A wrong gate shows only in the few combinations where exactly one of them disagrees. The stimulus therefore sweeps every pairing of write set, read set, write index and read index. Each pairing is checked in the cycle of its write, with the other port pointed at the written register, and is then committed so that later pairings read back what earlier ones stored. A reset asserted during an active write, with the read port aimed at that register, confirms that the reset suppresses both the forwarding and the commit.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // Default geometry of the register file
    localparam int RF_DEF_NREG  = 32;
    localparam int RF_DEF_XLEN  = 32;
    localparam int RF_DEF_NBANK = 2;

    // Widest index and set fields the helper functions accept
    localparam int RF_IDX_MAXW  = 8;
    localparam int RF_BANK_MAXW = 4;

    typedef logic [RF_IDX_MAXW-1:0]  idx_wide_t;
    typedef logic [RF_BANK_MAXW-1:0] bank_wide_t;

    // Named set codes
    typedef enum logic [RF_BANK_MAXW-1:0] {
        SET_MAIN   = 4'd0,
        SET_SHADOW = 4'd1
    } set_code_e;

    // Decoded write request, widened to the package limits
    typedef struct packed {
        logic       live;   // write really happens this cycle
        bank_wide_t bank;
        idx_wide_t  idx;
    } wr_tag_t;

    // A write forwards onto a read when both name the same nonzero
    // register of the same set and the write is live.
    function automatic logic fwd_hit(input wr_tag_t w,
                                     input bank_wide_t rbank,
                                     input idx_wide_t ridx);
        return w.live && (w.bank == rbank) && (w.idx == ridx)
               && (ridx != '0);
    endfunction

    // Flat position of register (bank, idx) inside the storage vector
    function automatic int slot_of(input int bank, input int idx,
                                   input int nreg);
        return bank * nreg + idx;
    endfunction

endpackage

// File: rtl/rf_write_dec.sv
module rf_write_dec
    import rf_pkg::*;
#(
    parameter int NREG  = RF_DEF_NREG,
    parameter int NBANK = RF_DEF_NBANK,
    localparam int IDXW  = $clog2(NREG),
    localparam int BSW   = $clog2(NBANK),
    localparam int SLOTS = NREG * NBANK
) (
    input  logic             rst,
    input  logic             wr_en,
    input  logic [BSW-1:0]   wr_bank,
    input  logic [IDXW-1:0]  wr_idx,
    output wr_tag_t          tag,
    output logic [SLOTS-1:0] slot_we
);

    // Live write: enabled, not in reset, and not aimed at index 0
    always_comb begin
        tag.live = wr_en && !rst && (wr_idx != '0);
        tag.bank = bank_wide_t'(wr_bank);
        tag.idx  = idx_wide_t'(wr_idx);
    end

    // One-hot enable per storage slot; index 0 slots stay unused
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            if (r == 0) begin : g_zero
                assign slot_we[slot_of(b, r, NREG)] = 1'b0;
            end else begin : g_live
                assign slot_we[slot_of(b, r, NREG)] =
                    tag.live && (tag.bank == bank_wide_t'(b))
                    && (tag.idx == idx_wide_t'(r));
            end
        end
    end

endmodule

// File: rtl/rf_bank_store.sv
module rf_bank_store
    import rf_pkg::*;
#(
    parameter int NREG  = RF_DEF_NREG,
    parameter int XLEN  = RF_DEF_XLEN,
    parameter int NBANK = RF_DEF_NBANK,
    localparam int SLOTS = NREG * NBANK
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SLOTS-1:0]      slot_we,
    input  logic [XLEN-1:0]       wr_data,
    output logic [SLOTS*XLEN-1:0] words
);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            localparam int S = slot_of(b, r, NREG);
            if (r == 0) begin : g_zero
                // Hard-wired zero register, no storage
                assign words[S*XLEN +: XLEN] = '0;
            end else begin : g_flop
                logic [XLEN-1:0] q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        q <= '0;
                    end else if (slot_we[S]) begin
                        q <= wr_data;
                    end
                end
                assign words[S*XLEN +: XLEN] = q;
            end
        end
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
#(
    parameter int NREG  = RF_DEF_NREG,
    parameter int XLEN  = RF_DEF_XLEN,
    parameter int NBANK = RF_DEF_NBANK,
    localparam int IDXW  = $clog2(NREG),
    localparam int BSW   = $clog2(NBANK),
    localparam int SLOTS = NREG * NBANK
) (
    input  logic [SLOTS*XLEN-1:0] words,
    input  logic [BSW-1:0]        rbank,
    input  logic [IDXW-1:0]       ridx,
    input  wr_tag_t               wtag,
    input  logic [XLEN-1:0]       wdata,
    output logic [XLEN-1:0]       rdata
);

    logic [XLEN-1:0] stored;
    logic            bypass;

    always_comb begin
        stored = '0;
        for (int b = 0; b < NBANK; b++) begin
            for (int r = 0; r < NREG; r++) begin
                if (rbank == BSW'(b) && ridx == IDXW'(r)) begin
                    stored = words[slot_of(b, r, NREG)*XLEN +: XLEN];
                end
            end
        end
    end

    assign bypass = fwd_hit(wtag, bank_wide_t'(rbank), idx_wide_t'(ridx));
    assign rdata  = bypass ? wdata : stored;

endmodule

// File: rtl/rf_banked.sv
module rf_banked
    import rf_pkg::*;
#(
    parameter int NREG  = RF_DEF_NREG,
    parameter int XLEN  = RF_DEF_XLEN,
    parameter int NBANK = RF_DEF_NBANK,
    localparam int IDXW  = $clog2(NREG),
    localparam int BSW   = $clog2(NBANK),
    localparam int SLOTS = NREG * NBANK
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [BSW-1:0]  rd_bank,
    input  logic [IDXW-1:0] a_idx,
    output logic [XLEN-1:0] a_data,
    input  logic [IDXW-1:0] b_idx,
    output logic [XLEN-1:0] b_data,
    input  logic            wr_en,
    input  logic [BSW-1:0]  wr_bank,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [XLEN-1:0] wr_data
);

    wr_tag_t               wtag;
    logic [SLOTS-1:0]      slot_we;
    logic [SLOTS*XLEN-1:0] words;

    rf_write_dec #(.NREG(NREG), .NBANK(NBANK)) u_dec (
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_idx  (wr_idx),
        .tag     (wtag),
        .slot_we (slot_we)
    );

    rf_bank_store #(.NREG(NREG), .XLEN(XLEN), .NBANK(NBANK)) u_store (
        .clk     (clk),
        .rst     (rst),
        .slot_we (slot_we),
        .wr_data (wr_data),
        .words   (words)
    );

    rf_read_port #(.NREG(NREG), .XLEN(XLEN), .NBANK(NBANK)) u_port_a (
        .words (words),
        .rbank (rd_bank),
        .ridx  (a_idx),
        .wtag  (wtag),
        .wdata (wr_data),
        .rdata (a_data)
    );

    rf_read_port #(.NREG(NREG), .XLEN(XLEN), .NBANK(NBANK)) u_port_b (
        .words (words),
        .rbank (rd_bank),
        .ridx  (b_idx),
        .wtag  (wtag),
        .wdata (wr_data),
        .rdata (b_data)
    );

endmodule

// File: rtl/rf_banked_chk.sv
module rf_banked_chk #(
    parameter int NREG  = 32,
    parameter int XLEN  = 32,
    parameter int NBANK = 2,
    localparam int IDXW = $clog2(NREG),
    localparam int BSW  = $clog2(NBANK)
) (
    input logic            clk,
    input logic            rst,
    input logic [BSW-1:0]  rd_bank,
    input logic [IDXW-1:0] a_idx,
    input logic [XLEN-1:0] a_data,
    input logic [IDXW-1:0] b_idx,
    input logic [XLEN-1:0] b_data,
    input logic            wr_en,
    input logic [BSW-1:0]  wr_bank,
    input logic [IDXW-1:0] wr_idx,
    input logic [XLEN-1:0] wr_data
);

    AST_ZERO_A: assert property (@(posedge clk) disable iff (rst)
        (a_idx == '0) |-> (a_data == '0)); // R4
    AST_ZERO_B: assert property (@(posedge clk) disable iff (rst)
        (b_idx == '0) |-> (b_data == '0)); // R4
    AST_FWD_A: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_bank == rd_bank && wr_idx == a_idx && a_idx != '0)
        |-> (a_data == wr_data)); // R5
    AST_FWD_B: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_bank == rd_bank && wr_idx == b_idx && b_idx != '0)
        |-> (b_data == wr_data)); // R5
    AST_COMMIT_A: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != '0) |=>
        ((rd_bank == $past(wr_bank) && a_idx == $past(wr_idx)
          && !(wr_en && wr_bank == $past(wr_bank) && wr_idx == $past(wr_idx)))
         -> (a_data == $past(wr_data)))); // R3
    AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
        (a_idx == b_idx) |-> (a_data == b_data)); // R9
    AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> ((!wr_en && $stable(a_idx) && $stable(rd_bank))
                      -> $stable(a_data))); // R8
    AST_CLEARED: assert property (@(posedge clk)
        rst |=> ((!rst && !wr_en) -> (a_data == '0 && b_data == '0))); // R7

endmodule

bind rf_banked rf_banked_chk #(.NREG(NREG), .XLEN(XLEN), .NBANK(NBANK)) u_chk (.*);

// File: tb/tb_rf_banked.sv
`timescale 1ns/1ps
module tb_rf_banked;

    localparam int NREG  = 32;
    localparam int XLEN  = 32;
    localparam int NBANK = 2;
    localparam int IDXW  = $clog2(NREG);
    localparam int BSW   = $clog2(NBANK);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [BSW-1:0]  rd_bank = '0;
    logic [IDXW-1:0] a_idx = '0;
    logic [IDXW-1:0] b_idx = '0;
    logic [XLEN-1:0] a_data, b_data;
    logic            wr_en = 1'b0;
    logic [BSW-1:0]  wr_bank = '0;
    logic [IDXW-1:0] wr_idx = '0;
    logic [XLEN-1:0] wr_data = '0;

    int checks = 0;
    int errors = 0;
    logic [XLEN-1:0] mdl [NBANK][NREG];

    always #5 clk = ~clk;

    rf_banked #(.NREG(NREG), .XLEN(XLEN), .NBANK(NBANK)) dut (.*);

    function automatic logic [XLEN-1:0] pat(input int b, input int i, input int s);
        return ((XLEN'(s) + 1) * 32'h9E37_79B9) ^ (XLEN'(b) << 31)
               ^ (XLEN'(i) << 8) ^ 32'h0000_005A;
    endfunction

    task automatic chk(input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int b = 0; b < NBANK; b++)
            for (int i = 0; i < NREG; i++) mdl[b][i] = '0;
    endtask

    // Read every register of every set through both ports, no writes
    task automatic sweep_all(input string req);
        wr_en = 1'b0;
        for (int b = 0; b < NBANK; b++) begin
            for (int i = 0; i < NREG; i++) begin
                rd_bank = BSW'(b);
                a_idx = IDXW'(i);
                b_idx = IDXW'((i + 7) % NREG);
                #0.1;
                chk(req, a_data, mdl[b][i]);
                chk(req, b_data, mdl[b][(i + 7) % NREG]);
            end
        end
    endtask

    initial begin : watchdog
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [XLEN-1:0] e;
        clear_model();
        // Write attempt during reset must be dropped (R7)
        @(negedge clk);
        wr_en = 1'b1; wr_bank = '0; wr_idx = 5; wr_data = 32'hDEAD_BEEF;
        rd_bank = '0; a_idx = 5;
        #1 chk("R7 no forward in reset", a_data, 32'h0);
        @(negedge clk);
        wr_en = 1'b0; rst = 1'b0;
        #1 sweep_all("R7 reset clears");

        // Fill all registers; check forwarding and cross-set isolation
        for (int b = 0; b < NBANK; b++) begin
            for (int i = 0; i < NREG; i++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_bank = BSW'(b); wr_idx = IDXW'(i);
                wr_data = pat(b, i, 0);
                rd_bank = BSW'(b); a_idx = IDXW'(i); b_idx = IDXW'(i);
                #1;
                e = (i == 0) ? '0 : pat(b, i, 0);
                chk("R5 fill forward A", a_data, e);
                chk("R4/R9 fill forward B", b_data, e);
                rd_bank = BSW'(1 - b);
                #0.1 chk("R6 fill other set", a_data, mdl[1-b][i]);
                @(posedge clk);
                if (i != 0) mdl[b][i] = pat(b, i, 0);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        #1 sweep_all("R1/R2/R3 readback");

        // Disabled write leaves contents untouched (R8)
        @(negedge clk);
        wr_en = 1'b0; wr_bank = 1; wr_idx = 7; wr_data = 32'h1234_5678;
        rd_bank = 1; a_idx = 7;
        #1 chk("R8 no forward when disabled", a_data, mdl[1][7]);
        @(negedge clk);
        #1 chk("R8 no commit when disabled", a_data, mdl[1][7]);

        // Full sweep over write set, read set, write index, read index
        for (int wb = 0; wb < NBANK; wb++) begin
            for (int rb = 0; rb < NBANK; rb++) begin
                for (int wi = 0; wi < NREG; wi++) begin
                    for (int ri = 0; ri < NREG; ri++) begin
                        int s;
                        s = 1 + ((wb * NBANK + rb) * NREG + wi) * NREG + ri;
                        @(negedge clk);
                        wr_en = 1'b1; wr_bank = BSW'(wb); wr_idx = IDXW'(wi);
                        wr_data = pat(wb, wi, s);
                        rd_bank = BSW'(rb); a_idx = IDXW'(ri); b_idx = IDXW'(wi);
                        #1;
                        if (ri == 0) e = '0;
                        else if (wb == rb && wi == ri) e = pat(wb, wi, s);
                        else e = mdl[rb][ri];
                        chk((wb == rb) ? "R5 sweep port A" : "R6 sweep port A", a_data, e);
                        if (wi == 0) e = '0;
                        else if (wb == rb) e = pat(wb, wi, s);
                        else e = mdl[rb][wi];
                        chk("R4/R5/R6 sweep port B", b_data, e);
                        @(posedge clk);
                        if (wi != 0) mdl[wb][wi] = pat(wb, wi, s);
                    end
                end
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        #1 sweep_all("R1/R3 sweep readback");

        // Reset asserted during a live write: no forward, no commit (R7)
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_bank = 0; wr_idx = 3; wr_data = 32'hCAFE_F00D;
        rd_bank = 0; a_idx = 3;
        #1 chk("R7 no forward in reset", a_data, mdl[0][3]);
        @(negedge clk);
        wr_en = 1'b0; rst = 1'b0;
        clear_model();
        #1 sweep_all("R7 mid-run reset clears");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule